// File: doc/BRIEF.md
# Reset-Time Port Option Loader

This block configures the I/O ports of a small controller each time reset is released. It reads a fixed set of option bytes, one per clock, from the top 256-byte page of program memory (7F00h to 7FFFh) through a synchronous ROM read port with one cycle of latency. Program space ends below that page, so the option bytes are never fetched as code. The bytes give, for each port bit separately, the output form (push-pull or open drain) and whether a pull-up is present.

Loading takes place inside a timed window that starts when reset is released. The window length is a parameter counted in clock cycles. For the whole of reset and of the window the block raises a safe flag. The pad logic uses that flag to keep every pin as an input with its driver off, and the block itself holds every pull-up enable at zero. When the window ends the flag drops, the loaded pull-ups take effect, and a one-cycle start strobe lets the CPU begin fetching at address 0000h. If reset is asserted at any time, everything is cleared and loading begins again from the first option byte.

The controller has four states. ST_LOAD issues the reads. It moves to ST_HOLD once the last read has been issued. ST_HOLD waits until the window counter expires and then moves to ST_RELEASE. ST_RELEASE lasts one cycle, drives the start strobe and moves to ST_RUN. ST_RUN holds until the next reset. Reset from any state returns to ST_LOAD.

Top module: `port_opt_loader`

## Requirements
- R1: While `rst_n` is low: `port_safe_o` = 1, `cpu_start_o` = 0, `port_od_o` = 0, `port_pu_o` = 0 and `rom_addr_o` = 7F00h.
- R2: Let e be the number of rising edges since reset was released. After edge e, `rom_addr_o` = 7F00h + min(e, 2·NUM_PINS/8). The address never leaves the range 7F00h to 7FFFh.
- R3: Let B = NUM_PINS/8. Option byte 7F00h+i, for i < B, sets `port_od_o[8i+7:8i]`, where bit value 1 selects open drain and 0 selects push-pull. The byte appears on the output after edge i+2.
- R4: Option byte 7F00h+B+j sets `port_pu_o[8j+7:8j]`, where bit value 1 enables the pull-up. The output stays all zero until the window ends.
- R5: `port_safe_o` stays 1 until edge WINDOW_CYCLES and is 0 from then until the next reset. WINDOW_CYCLES must be at least 2·B+2.
- R6: `cpu_start_o` is 1 for exactly one cycle, the cycle after edge WINDOW_CYCLES.
- R7: After the window, `port_od_o` and `port_pu_o` hold their loaded values until the next reset.
- R8: Asserting reset during loading, during the wait or while running clears all options. The next release reloads every byte from 7F00h and restarts the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_data_i | input | 8 | ROM read data, one cycle after the address |
| rom_addr_o | output | 16 | ROM read address |
| port_od_o | output | NUM_PINS | Per-bit open-drain select |
| port_pu_o | output | NUM_PINS | Per-bit pull-up enable, zero while safe |
| port_safe_o | output | 1 | Pins forced to input, CPU held in reset |
| cpu_start_o | output | 1 | One-cycle CPU release strobe |

## Verification
Every result in this block is due a fixed number of edges after reset is released. The ROM address moves on the edge that issues each read, and option byte i appears two edges after that edge. The safe flag falls, the pull-ups appear and the start strobe pulses all on edge WINDOW_CYCLES. The bench counts edges since release with a reset-cleared counter and derives every expected output from that count and the ROM image. It samples on the falling edge so that each comparison sees the values settled after the preceding rising edge. It asserts reset mid-load, mid-wait and while running, and after each release it expects the loading sequence to start again from zero.

// File: rtl/pol_pkg.sv
package pol_pkg;
    typedef enum logic [1:0] {
        ST_LOAD    = 2'd0,
        ST_HOLD    = 2'd1,
        ST_RELEASE = 2'd2,
        ST_RUN     = 2'd3
    } pol_state_t;
endpackage

// File: rtl/pol_fetch.sv
module pol_fetch #(
    parameter int              ADDR_W = 16,
    parameter logic [15:0]     BASE   = 16'h7F00,
    parameter int              NBYTES = 8,
    parameter int              IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_en,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              cap_vld,
    output logic [IDX_W-1:0]  cap_idx,
    output logic              fetch_done
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NBYTES);

    logic [IDX_W-1:0] rd_idx;
    logic             issue;

    assign issue      = fetch_en && (rd_idx != LAST);
    assign fetch_done = (rd_idx == LAST);
    assign rom_addr   = ADDR_W'(BASE) + ADDR_W'(rd_idx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_idx  <= '0;
            cap_vld <= 1'b0;
            cap_idx <= '0;
        end else begin
            cap_vld <= issue;
            cap_idx <= rd_idx;
            if (issue) begin
                rd_idx <= rd_idx + 1'b1;
            end
        end
    end

    AST_CAP_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_vld |-> (cap_idx < LAST)); // R2
endmodule

// File: rtl/pol_store.sv
module pol_store #(
    parameter int NUM_PINS = 32,
    parameter int IDX_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_vld,
    input  logic [IDX_W-1:0]    cap_idx,
    input  logic [7:0]          rom_data,
    output logic [NUM_PINS-1:0] od_vec,
    output logic [NUM_PINS-1:0] pu_vec
);
    localparam int NPB = NUM_PINS / 8;

    for (genvar g = 0; g < NPB; g++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                od_vec[8*g +: 8] <= '0;
                pu_vec[8*g +: 8] <= '0;
            end else if (cap_vld) begin
                if (cap_idx == IDX_W'(g)) begin
                    od_vec[8*g +: 8] <= rom_data;
                end
                if (cap_idx == IDX_W'(NPB + g)) begin
                    pu_vec[8*g +: 8] <= rom_data;
                end
            end
        end
    end
endmodule

// File: rtl/pol_timer.sv
module pol_timer #(
    parameter int WINDOW = 30000,
    parameter int CNT_W  = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    output logic win_done
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WINDOW - 1);

    logic [CNT_W-1:0] cnt;

    assign win_done = (cnt == LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (count_en && !win_done) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT); // R5
endmodule

// File: rtl/port_opt_loader.sv
module port_opt_loader #(
    parameter int          NUM_PINS      = 32,
    parameter int          WINDOW_CYCLES = 30000,
    parameter logic [15:0] OPT_BASE      = 16'h7F00,
    parameter int          OPT_SIZE      = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          rom_data_i,
    output logic [15:0]         rom_addr_o,
    output logic [NUM_PINS-1:0] port_od_o,
    output logic [NUM_PINS-1:0] port_pu_o,
    output logic                port_safe_o,
    output logic                cpu_start_o
);
    import pol_pkg::*;

    localparam int NPB    = NUM_PINS / 8;
    localparam int NBYTES = 2 * NPB;
    localparam int IDX_W  = $clog2(NBYTES + 1);
    localparam int CNT_W  = $clog2(WINDOW_CYCLES + 1);

    pol_state_t state, state_nx;

    logic                fetch_en;
    logic                cap_vld;
    logic [IDX_W-1:0]    cap_idx;
    logic                fetch_done;
    logic                win_done;
    logic                count_en;
    logic [NUM_PINS-1:0] od_vec;
    logic [NUM_PINS-1:0] pu_vec;

    pol_fetch #(
        .ADDR_W (16),
        .BASE   (OPT_BASE),
        .NBYTES (NBYTES),
        .IDX_W  (IDX_W)
    ) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_en   (fetch_en),
        .rom_addr   (rom_addr_o),
        .cap_vld    (cap_vld),
        .cap_idx    (cap_idx),
        .fetch_done (fetch_done)
    );

    pol_store #(
        .NUM_PINS (NUM_PINS),
        .IDX_W    (IDX_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_vld  (cap_vld),
        .cap_idx  (cap_idx),
        .rom_data (rom_data_i),
        .od_vec   (od_vec),
        .pu_vec   (pu_vec)
    );

    pol_timer #(
        .WINDOW (WINDOW_CYCLES),
        .CNT_W  (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .win_done (win_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_LOAD;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOAD:    if (fetch_done) state_nx = ST_HOLD;
            ST_HOLD:    if (win_done)   state_nx = ST_RELEASE;
            ST_RELEASE:                 state_nx = ST_RUN;
            ST_RUN:                     state_nx = ST_RUN;
            default:                    state_nx = ST_LOAD;
        endcase
    end

    // outputs
    always_comb begin
        fetch_en    = 1'b0;
        count_en    = 1'b0;
        port_safe_o = 1'b1;
        cpu_start_o = 1'b0;
        unique case (state)
            ST_LOAD: begin
                fetch_en = 1'b1;
                count_en = 1'b1;
            end
            ST_HOLD: begin
                count_en = 1'b1;
            end
            ST_RELEASE: begin
                port_safe_o = 1'b0;
                cpu_start_o = 1'b1;
            end
            ST_RUN: begin
                port_safe_o = 1'b0;
            end
            default: begin
                port_safe_o = 1'b1;
            end
        endcase
    end

    assign port_od_o = od_vec;
    assign port_pu_o = port_safe_o ? '0 : pu_vec;

    AST_ADDR_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_addr_o >= OPT_BASE) && (rom_addr_o < OPT_BASE + 16'(OPT_SIZE))); // R2
    AST_SAFE_EXIT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(port_safe_o) |-> cpu_start_o); // R5
    AST_SAFE_NO_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        !port_safe_o |=> !port_safe_o); // R5
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_start_o |=> !cpu_start_o); // R6
    AST_OD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !port_safe_o |=> $stable(port_od_o)); // R7
    AST_PU_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_safe_o && !cpu_start_o) |-> $stable(port_pu_o)); // R7
endmodule

// File: tb/port_opt_loader_bench.sv
module port_opt_loader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NPINS      = 32;
    localparam int WIN        = 20;
    localparam int NB         = NPINS / 4;
    localparam int NPB        = NPINS / 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [7:0]       rom_data = '0;
    logic [15:0]      rom_addr;
    logic [NPINS-1:0] od, pu;
    logic             safe, start;

    logic [7:0] mem [256];
    int edges = 0;
    int checks = 0;
    int errs = 0;
    int cyc = 0;
    bit reloaded = 1'b0;
    bit done = 1'b0;
    logic [NPINS-1:0] od_at_release = '0;
    logic [NPINS-1:0] pu_at_release = '0;

    port_opt_loader #(
        .NUM_PINS      (NPINS),
        .WINDOW_CYCLES (WIN)
    ) u_port_opt_loader (
        .clk         (clk),
        .rst_n       (rst_n),
        .rom_data_i  (rom_data),
        .rom_addr_o  (rom_addr),
        .port_od_o   (od),
        .port_pu_o   (pu),
        .port_safe_o (safe),
        .cpu_start_o (start)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural ROM, one cycle latency
    always @(posedge clk) rom_data <= mem[rom_addr[7:0]];

    // edges since reset release
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;
    end

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s at edge %0d: got %h expected %h", tag, edges, got, exp);
        end
    endtask

    always @(negedge clk) begin
        logic [15:0]      e_addr;
        logic [NPINS-1:0] e_od, e_pu;
        cyc++;
        if (!done) begin
            if (cyc > 5000) begin
                errs++; checks++;
                $display("FAIL watchdog: got hung expected finish");
                done = 1'b1;
                $display("Result: errors=%0d of %0d checks", errs, checks);
                $finish;
            end
            e_addr = 16'h7F00 + 16'((edges < NB) ? edges : NB);
            e_od = '0;
            e_pu = '0;
            for (int i = 0; i < NPB; i++) begin
                if (edges >= i + 2) e_od[8*i +: 8] = mem[i];
                if (edges >= WIN)   e_pu[8*i +: 8] = mem[NPB + i];
            end
            if (!rst_n) begin
                chk("R1 addr", 64'(rom_addr), 64'h7F00);
                chk("R1 od", 64'(od), 64'd0);
                chk("R1 pu", 64'(pu), 64'd0);
                chk("R1 safe", 64'(safe), 64'd1);
                chk("R1 start", 64'(start), 64'd0);
            end else begin
                chk("R2 addr", 64'(rom_addr), 64'(e_addr));
                chk(reloaded ? "R8 od reload" : "R3 od", 64'(od), 64'(e_od));
                chk(reloaded ? "R8 pu reload" : "R4 pu", 64'(pu), 64'(e_pu));
                chk("R5 safe", 64'(safe), 64'(edges < WIN));
                chk("R6 start", 64'(start), 64'(edges == WIN));
                if (edges == WIN) begin
                    od_at_release = od;
                    pu_at_release = pu;
                end
                if (edges > WIN) begin
                    chk("R7 od hold", 64'(od), 64'(od_at_release));
                    chk("R7 pu hold", 64'(pu), 64'(pu_at_release));
                end
            end
        end
    end

    task automatic release_rst();
        @(posedge clk); #(CLK_PERIOD/4);
        rst_n = 1'b1;
    endtask

    task automatic assert_rst();
        @(posedge clk); #(CLK_PERIOD/4);
        rst_n = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
        run(3);
        release_rst();
        run(WIN + 15);                // full load, release, run

        assert_rst();                 // R8: reset while running
        reloaded = 1'b1;
        for (int i = 0; i < 256; i++) mem[i] = 8'hA5 ^ 8'(i);
        run(2);
        release_rst();
        run(5);                       // R8: reset in the middle of loading

        assert_rst();
        for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
        run(2);
        release_rst();
        run(14);                      // R8: reset during the wait

        assert_rst();
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        run(2);
        release_rst();
        run(WIN + 5);                 // all-zero options

        assert_rst();
        for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
        run(1);
        release_rst();
        run(WIN + 10);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule